// File: doc/BRIEF.md
# Atomic Double-Word Compare-and-Swap Sequencer

This block carries out one atomic 64-bit compare-and-swap on a memory bus. A start pulse hands it an address, a comparand (either a full 64-bit register pair or a 13-bit immediate), and the 64-bit value held in the destination register pair. Once the address passes the alignment check, the block raises a bus lock and reads the double word. It then compares that word with the comparand. On a match it stores the destination value. On a mismatch it stores the word it just read back to the same address. The lock drops only after that store is acknowledged, so no other master can observe or change the location during the sequence.

The store always takes place, because the final write is what ends the locked sequence. When the compare matches, the destination register pair receives the old memory word through a write-enable strobe. When it does not match, the pair is left untouched, and software detects success by inspecting it afterwards. A single `done` pulse marks the end of every request. `success` flags a match and `err` flags a rejected, misaligned address.

Top module: `cas64_sequencer`

## Requirements
- R1: After reset, `bus_req`, `bus_lock`, `done`, `success`, `err` and `rd_we` are all low.
- R2: A start whose address has any of bits [2:0] set gives `done` and `err` high for exactly the following cycle. No bus request and no lock are issued.
- R3: `bus_lock` rises before the read request. It stays high without a gap until the write is acknowledged, and it is low in the cycle after that acknowledge.
- R4: An accepted start produces exactly one read and then exactly one write (`bus_we`=1), both at the start address.
- R5: When the read word equals the comparand, the write carries the swap value. `done`, `success` and `rd_we` are then high together, with `rd_wdata` equal to the old memory word.
- R6: When the read word differs from the comparand, the write carries the read word unchanged. `done` is high, while `success` and `rd_we` stay low.
- R7: With `imm_sel`=1 the comparand is `imm_val` sign-extended from 13 bits to 64 bits. With `imm_sel`=0 it is `cmp_pair`.
- R8: With `alt_space`=1 both transfers carry `asi_in` on `bus_asi`. Otherwise they carry the parameter DEF_ASI (default 8'h0B).
- R9: A start pulse that arrives while a sequence is in progress is ignored. No extra transfer and no extra `done` follow.
- R10: `done` lasts one cycle for a completed sequence.
- R11: A competing requester that is arbitrated only while `bus_lock` is low is never granted between the read and the release of the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| addr | input | ADDR_W | Double-word address |
| imm_sel | input | 1 | 1: comparand from immediate |
| imm_val | input | IMM_W | Signed immediate comparand |
| cmp_pair | input | DATA_W | Register-pair comparand |
| swap_val | input | DATA_W | Destination pair value to store on match |
| alt_space | input | 1 | Use `asi_in` as the address space |
| asi_in | input | ASI_W | Alternate address-space identifier |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1: write, 0: read |
| bus_lock | output | 1 | Bus lock held for the atomic sequence |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Write data |
| bus_asi | output | ASI_W | Address space of the transfer |
| bus_ack | input | 1 | One-cycle transfer acknowledge |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| rd_we | output | 1 | Destination pair write enable |
| rd_wdata | output | DATA_W | Old memory word for the destination pair |
| done | output | 1 | End-of-request pulse |
| success | output | 1 | Compare matched (with `done`) |
| err | output | 1 | Misaligned address rejected (with `done`) |

## Verification
The assertions assume the bus acknowledges only while `bus_req` is high, for one cycle per transfer, and that `bus_rdata` is valid in that cycle. The bench memory responder meets this: it waits a fixed latency after it sees a request, pulses `bus_ack` once, and then waits for a fresh request before it counts again. Under that contract, the properties on write-data stability and on lock continuity depend only on the sequencer. The competing requester is modelled purely in the bench: an arbiter grants it only in cycles where the sequencer holds neither lock nor request.

// File: rtl/cas64_sequencer.sv
module cas64_sequencer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IMM_W  = 13,
  parameter int ASI_W  = 8,
  parameter logic [ASI_W-1:0] DEF_ASI = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [DATA_W-1:0] cmp_pair,
  input  logic [DATA_W-1:0] swap_val,
  input  logic              alt_space,
  input  logic [ASI_W-1:0]  asi_in,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_lock,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ASI_W-1:0]  bus_asi,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_we,
  output logic [DATA_W-1:0] rd_wdata,
  output logic              done,
  output logic              success,
  output logic              err
);
  localparam int ALIGN_W = $clog2(DATA_W / 8);

  typedef enum logic [2:0] {
    S_IDLE, S_LOCK_RD, S_WAIT_RD, S_CMP, S_WR, S_WAIT_WR, S_DONE
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] cmp_q, new_q, old_q, wdata_q;
  logic [ASI_W-1:0]  asi_q;
  logic              hit_q, err_q;

  wire misaligned = addr[ALIGN_W-1:0] != '0;
  wire [DATA_W-1:0] cmp_sel = imm_sel ?
    {{(DATA_W-IMM_W){imm_val[IMM_W-1]}}, imm_val} : cmp_pair;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      cmp_q   <= '0;
      new_q   <= '0;
      old_q   <= '0;
      wdata_q <= '0;
      asi_q   <= '0;
      hit_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (misaligned) begin
            err_q <= 1'b1;
          end else begin
            addr_q <= addr;
            cmp_q  <= cmp_sel;
            new_q  <= swap_val;
            asi_q  <= alt_space ? asi_in : DEF_ASI;
            st     <= S_LOCK_RD;
          end
        end
        S_LOCK_RD: st <= S_WAIT_RD;
        S_WAIT_RD: if (bus_ack) begin
          old_q <= bus_rdata;
          st    <= S_CMP;
        end
        S_CMP: begin
          hit_q   <= old_q == cmp_q;
          wdata_q <= (old_q == cmp_q) ? new_q : old_q;
          st      <= S_WR;
        end
        S_WR:      st <= S_WAIT_WR;
        S_WAIT_WR: if (bus_ack) st <= S_DONE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = st == S_WAIT_RD || st == S_WAIT_WR;
  assign bus_we    = st == S_WAIT_WR;
  assign bus_lock  = st != S_IDLE && st != S_DONE;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_asi   = asi_q;
  assign done      = st == S_DONE || err_q;
  assign success   = st == S_DONE && hit_q;
  assign rd_we     = success;
  assign rd_wdata  = old_q;
  assign err       = err_q;

  a_r3_req_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_lock);
  a_r3_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock && !(bus_req && bus_we && bus_ack) |=> bus_lock);
  a_r3_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ack |=> !bus_lock && done);
  a_r2_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_req && !bus_lock && done && !success);
  a_r5_we_with_success: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> success && done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |=> !done);
  a_r4_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we));
endmodule

// File: tb/cas64_sequencer_bench.sv
module cas64_sequencer_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic start = 0, imm_sel = 0, alt_space = 0;
  logic [31:0] addr = 0;
  logic [12:0] imm_val = 0;
  logic [63:0] cmp_pair = 0, swap_val = 0;
  logic [7:0]  asi_in = 0;
  logic bus_req, bus_we, bus_lock, bus_ack, rd_we, done, success, err;
  logic [31:0] bus_addr;
  logic [63:0] bus_wdata, bus_rdata, rd_wdata;
  logic [7:0]  bus_asi;

  cas64_sequencer u_cas64_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .imm_sel(imm_sel),
    .imm_val(imm_val), .cmp_pair(cmp_pair), .swap_val(swap_val),
    .alt_space(alt_space), .asi_in(asi_in), .bus_req(bus_req), .bus_we(bus_we),
    .bus_lock(bus_lock), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_asi(bus_asi), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .rd_we(rd_we),
    .rd_wdata(rd_wdata), .done(done), .success(success), .err(err));

  logic [63:0] mem [0:15];
  logic [1:0]  cnt = 0;
  int n_rd = 0, n_wr = 0, n_done = 0, drops = 0, grants = 0;
  logic [31:0] rd_addr = 0, wr_addr = 0;
  logic [63:0] wr_data = 0;
  logic [7:0]  asi_rd = 0, asi_wr = 0;
  logic lock_prev = 0, wdone = 0, orq = 0, ogrant = 0;
  int checks = 0, errors = 0;

  initial begin bus_ack = 0; bus_rdata = 0; end

  always @(posedge clk) begin
    bus_ack <= 1'b0;
    if (bus_req && !bus_ack) begin
      if (cnt == 2'd2) begin
        cnt <= 0;
        bus_ack <= 1'b1;
        if (bus_we) begin
          mem[bus_addr[6:3]] <= bus_wdata;
          n_wr <= n_wr + 1; wr_addr <= bus_addr; wr_data <= bus_wdata; asi_wr <= bus_asi;
        end else begin
          bus_rdata <= mem[bus_addr[6:3]];
          n_rd <= n_rd + 1; rd_addr <= bus_addr; asi_rd <= bus_asi;
        end
      end else cnt <= cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (bus_req && bus_ack && bus_we) wdone <= 1'b1;
    else if (!lock_prev && bus_lock) wdone <= 1'b0;
    if (lock_prev && !bus_lock && !wdone) drops <= drops + 1;
    lock_prev <= bus_lock;
    ogrant <= orq && !bus_lock && !bus_req;
    if (ogrant) grants <= grants + 1;
    if (done) n_done <= n_done + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input bit isel, input logic [12:0] imm,
                        input logic [63:0] cmpv, input logic [63:0] swv,
                        input bit alt, input logic [7:0] asi);
    @(negedge clk);
    addr = a; imm_sel = isel; imm_val = imm; cmp_pair = cmpv; swap_val = swv;
    alt_space = alt; asi_in = asi; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check(!bus_req && !bus_lock && !done && !success && !err && !rd_we, "R1",
          {58'd0, bus_req, bus_lock, done, success, err, rd_we}, 64'd0);
  endtask

  task automatic t_match;
    int r0 = n_rd, w0 = n_wr;
    mem[2] = 64'h1122_3344_5566_7788;
    run_op(32'h10, 0, 0, 64'h1122_3344_5566_7788, 64'hCAFE_F00D_DEAD_BEEF, 0, 0);
    check(done && success && rd_we, "R5", {61'd0, done, success, rd_we}, 64'd7);
    check(rd_wdata == 64'h1122_3344_5566_7788, "R5", rd_wdata, 64'h1122_3344_5566_7788);
    check(mem[2] == 64'hCAFE_F00D_DEAD_BEEF, "R5", mem[2], 64'hCAFE_F00D_DEAD_BEEF);
    check(n_rd == r0 + 1 && n_wr == w0 + 1, "R4", 64'(n_rd - r0), 64'd1);
    check(rd_addr == 32'h10 && wr_addr == 32'h10, "R4", {32'd0, wr_addr}, 64'h10);
    check(asi_rd == 8'h0B && asi_wr == 8'h0B, "R8", {56'd0, asi_wr}, 64'h0B);
    check(drops == 0, "R3", 64'(drops), 64'd0);
    @(negedge clk);
    check(!done && !bus_lock, "R10", {62'd0, done, bus_lock}, 64'd0);
  endtask

  task automatic t_mismatch;
    mem[5] = 64'h0000_0000_0000_00AA;
    run_op(32'h28, 0, 0, 64'h0000_0000_0000_00AB, 64'h5555_5555_5555_5555, 1, 8'h3C);
    check(done && !success && !rd_we, "R6", {61'd0, done, success, rd_we}, 64'd4);
    check(wr_data == 64'hAA && mem[5] == 64'hAA, "R6", wr_data, 64'hAA);
    check(wr_addr == 32'h28, "R6", {32'd0, wr_addr}, 64'h28);
    check(asi_rd == 8'h3C && asi_wr == 8'h3C, "R8", {56'd0, asi_rd}, 64'h3C);
  endtask

  task automatic t_imm;
    mem[7] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_op(32'h38, 1, 13'h1FFF, 64'd0, 64'h0123_4567_89AB_CDEF, 0, 0);
    check(success && mem[7] == 64'h0123_4567_89AB_CDEF, "R7", mem[7], 64'h0123_4567_89AB_CDEF);
    mem[8] = 64'h0000_0000_0000_0FFF;
    run_op(32'h40, 1, 13'h0FFF, 64'h0, 64'h9, 0, 0);
    check(success && rd_wdata == 64'hFFF, "R7", rd_wdata, 64'hFFF);
    mem[9] = 64'h0000_0000_0000_1FFF;
    run_op(32'h48, 1, 13'h1FFF, 64'h1FFF, 64'h9, 0, 0);
    check(!success && mem[9] == 64'h1FFF, "R7", mem[9], 64'h1FFF);
  endtask

  task automatic t_misalign;
    int r0 = n_rd;
    @(negedge clk);
    addr = 32'h14; imm_sel = 0; start = 1;
    @(negedge clk);
    start = 0;
    check(done && err && !success, "R2", {61'd0, done, err, success}, 64'd6);
    check(!bus_req && !bus_lock, "R2", {62'd0, bus_req, bus_lock}, 64'd0);
    @(negedge clk);
    check(!done && !err, "R2", {62'd0, done, err}, 64'd0);
    repeat (6) @(negedge clk);
    check(n_rd == r0, "R2", 64'(n_rd - r0), 64'd0);
  endtask

  task automatic t_busy_start;
    int r0 = n_rd, w0 = n_wr, d0;
    mem[3] = 64'h77;
    @(negedge clk);
    addr = 32'h18; imm_sel = 0; cmp_pair = 64'h77; swap_val = 64'h99; alt_space = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    addr = 32'h20; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    d0 = n_done;
    repeat (10) @(negedge clk);
    check(n_rd == r0 + 1 && n_wr == w0 + 1, "R9", 64'(n_wr - w0), 64'd1);
    check(n_done == d0 + 1 && wr_addr == 32'h18, "R9", 64'(n_done - d0), 64'd1);
    check(mem[3] == 64'h99, "R9", mem[3], 64'h99);
  endtask

  task automatic t_lockout;
    int g0;
    mem[4] = 64'h42;
    @(negedge clk);
    addr = 32'h20; imm_sel = 0; cmp_pair = 64'h42; swap_val = 64'h43; alt_space = 0; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 10 && !bus_lock; i++) @(negedge clk);
    orq = 1;
    @(negedge clk);
    g0 = grants;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    check(grants == g0, "R11", 64'(grants - g0), 64'd0);
    repeat (3) @(negedge clk);
    check(grants > g0, "R11", 64'(grants - g0), 64'd1);
    orq = 0;
    check(drops == 0 && mem[4] == 64'h43, "R3", 64'(drops), 64'd0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 64'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_match();
    t_mismatch();
    t_imm();
    t_misalign();
    t_busy_start();
    t_lockout();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule